// File: doc/BRIEF.md
# Elastic Store with Fractional-Bit Output Trim

This block sits in a serial line path and soaks up the timing wander of the incoming bit stream. Each rising edge of the line strobe writes one entry into a small circular store. An entry is either one NRZ bit or a positive/negative rail pair, chosen by a width parameter. The block reads entries back out on a bit-rate enable that it makes itself from a reference clock running at eight times the nominal bit rate. All logic runs on that reference clock. The line strobe and its data are synchronised together and edge-detected before any write.

The block keeps count of how many entries the store holds. At the end of every output bit period it looks at that count and picks the length of the next period. Near full, the next period is one reference tick shorter, so the store drains a little faster. Near empty, the next period is one tick longer, so the store fills. Otherwise the period stays at its nominal length. This moves the output rate in one-eighth-bit steps rather than slipping whole bits. After reset the store holds half its depth in zero entries, so a bit sees on average half the depth (16 bits) of delay. If the two sides still collide, a sticky flag records it and the store re-centres.

The write side is a timing source and cannot be stalled. The read side offers `rd_valid_o` without a ready: there is no back-pressure, and the consumer must take `rd_data_o` in the single cycle that `rd_valid_o` is high. `DEPTH` must be a power of two.

Top module: `es_elastic_store`

## Requirements
- R1: After reset, fill_o reads DEPTH/2 (16), ovf_o, udf_o, trim_fast_o, trim_slow_o and rd_valid_o are low, and rd_data_o is zero.
- R2: Entries leave in the order they were written. After reset the first DEPTH/2 entries read out are zero, which gives a latency of DEPTH/2 bit periods. fill_o never exceeds DEPTH.
- R3: The fill is the value of fill_o in the cycle in which a bit period ends. When that fill lies strictly between GUARD and DEPTH-GUARD, the next output period lasts NOM_TICKS (8) reference cycles.
- R4: When the fill at a period end is DEPTH-GUARD (30) or more, the next period lasts NOM_TICKS-1 (7) cycles.
- R5: When the fill at a period end is GUARD (2) or less, the next period lasts NOM_TICKS+1 (9) cycles.
- R6: rd_valid_o is a one-cycle pulse, once per output period, one cycle after the period ends. Each period carries at most one trim.
- R7: A write while the store is full and no read is happening sets ovf_o and sets fill_o to DEPTH/2. ovf_o stays set until reset.
- R8: A read while the store is empty sets udf_o and sets fill_o to DEPTH/2. udf_o stays set until reset.
- R9: Each rising edge of line_clk_i writes exactly one entry, however long the strobe stays high. line_data_i is captured with the strobe.
- R10: trim_fast_o is high throughout a shortened period and trim_slow_o is high throughout a lengthened one. Both change in the cycle rd_valid_o pulses, and they are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, eight times the bit rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_clk_i | input | 1 | Incoming line bit strobe (asynchronous) |
| line_data_i | input | ENTRY_W | Incoming bit or rail pair |
| rd_data_o | output | ENTRY_W | Entry read out, valid with rd_valid_o |
| rd_valid_o | output | 1 | Output bit enable, one-cycle pulse |
| fill_o | output | $clog2(DEPTH)+1 | Entries held in the store |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |
| trim_fast_o | output | 1 | Current output period is shortened |
| trim_slow_o | output | 1 | Current output period is lengthened |

## Verification
The bench builds the block with ENTRY_W set to 2, so every stored entry is a rail pair. DEPTH stays at 32, GUARD at 2 and NOM_TICKS at 8. Depth 32 keeps the trim thresholds at fills of 30 and 2. A line period one tick fast or slow then reaches each threshold within a few hundred bits, and a line period three ticks fast reaches overflow soon after. The two-bit entries let the scoreboard tell the rail pairs apart, so it catches a swapped, doubled or dropped entry as well as a wrong single bit.

// File: rtl/es_pkg.sv
package es_pkg;

  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_FAST = 2'd1,
    TRIM_SLOW = 2'd2
  } trim_e;

  // Choose the trim for the next output period from the current fill.
  function automatic trim_e es_pick_trim(input int unsigned fill,
                                         input int unsigned depth,
                                         input int unsigned guard);
    if (fill >= depth - guard) return TRIM_FAST;
    if (fill <= guard)         return TRIM_SLOW;
    return TRIM_NONE;
  endfunction

endpackage

// File: rtl/es_line_sync.sv
module es_line_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         line_clk_i,
  input  logic [W-1:0] line_data_i,
  output logic         wr_pulse_o,
  output logic [W-1:0] wr_data_o
);

  logic [STAGES-1:0] strobe_pipe;
  logic [W-1:0]      data_pipe [STAGES];
  logic              strobe_prev;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      strobe_pipe <= '0;
      strobe_prev <= 1'b0;
    end else begin
      strobe_pipe <= {strobe_pipe[STAGES-2:0], line_clk_i};
      strobe_prev <= strobe_pipe[STAGES-1];
    end
  end

  // Data travels through a matching chain so it lines up with the edge.
  for (genvar s = 0; s < STAGES; s++) begin : g_data_stage
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        data_pipe[s] <= '0;
      end else if (s == 0) begin
        data_pipe[s] <= line_data_i;
      end else begin
        data_pipe[s] <= data_pipe[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign wr_pulse_o = strobe_pipe[STAGES-1] & ~strobe_prev;
  assign wr_data_o  = data_pipe[STAGES-1];

endmodule

// File: rtl/es_store.sv
module es_store #(
  parameter int DEPTH = 32,
  parameter int W     = 1,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         rd_valid_o,
  output logic [AW:0]  fill_o,
  output logic         ovf_o,
  output logic         udf_o
);

  localparam int HALF = DEPTH / 2;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_nxt;
  logic [AW:0]   count;
  logic          full, empty, ovf_ev, udf_ev;

  assign full     = (count == (AW+1)'(DEPTH));
  assign empty    = (count == '0);
  assign ovf_ev   = wr_i && !rd_i && full;
  assign udf_ev   = rd_i && empty;
  assign wptr_nxt = wptr + AW'(wr_i);

  for (genvar e = 0; e < DEPTH; e++) begin : g_cell
    always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
        mem[e] <= '0;
      end else if (wr_i && (wptr == AW'(e))) begin
        mem[e] <= wr_data_i;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      wptr       <= AW'(HALF);
      rptr       <= '0;
      count      <= (AW+1)'(HALF);
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      ovf_o      <= 1'b0;
      udf_o      <= 1'b0;
    end else begin
      wptr       <= wptr_nxt;
      rd_valid_o <= rd_i;
      if (rd_i) rd_data_o <= mem[rptr];
      if (ovf_ev || udf_ev) begin
        // Collision: restore the half-depth spacing behind the writer.
        rptr  <= wptr_nxt - AW'(HALF);
        count <= (AW+1)'(HALF);
      end else begin
        if (rd_i) rptr <= rptr + AW'(1);
        count <= count + (AW+1)'(wr_i) - (AW+1)'(rd_i);
      end
      if (ovf_ev) ovf_o <= 1'b1;
      if (udf_ev) udf_o <= 1'b1;
    end
  end

  assign fill_o = count;

endmodule

// File: rtl/es_trim_clock.sv
module es_trim_clock
  import es_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int GUARD = 2,
  parameter int NOM   = 8,
  parameter int FW    = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [FW-1:0] fill_i,
  output logic          tick_o,
  output logic          fast_o,
  output logic          slow_o
);

  localparam int CW = $clog2(NOM + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] len;
  trim_e         pick;

  assign tick_o = (cnt == '0);
  assign pick   = es_pick_trim(int'(fill_i), DEPTH, GUARD);

  always_comb begin
    unique case (pick)
      TRIM_FAST: len = CW'(NOM - 1);
      TRIM_SLOW: len = CW'(NOM + 1);
      default:   len = CW'(NOM);
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt    <= CW'(NOM - 1);
      fast_o <= 1'b0;
      slow_o <= 1'b0;
    end else if (tick_o) begin
      cnt    <= len - CW'(1);
      fast_o <= (pick == TRIM_FAST);
      slow_o <= (pick == TRIM_SLOW);
    end else begin
      cnt <= cnt - CW'(1);
    end
  end

endmodule

// File: rtl/es_elastic_store.sv
module es_elastic_store #(
  parameter int DEPTH       = 32,
  parameter int ENTRY_W     = 1,
  parameter int GUARD       = 2,
  parameter int NOM_TICKS   = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FW         = $clog2(DEPTH) + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_clk_i,
  input  logic [ENTRY_W-1:0] line_data_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               rd_valid_o,
  output logic [FW-1:0]      fill_o,
  output logic               ovf_o,
  output logic               udf_o,
  output logic               trim_fast_o,
  output logic               trim_slow_o
);

  logic               wr_pulse;
  logic [ENTRY_W-1:0] wr_data;
  logic               rd_tick;

  es_line_sync #(.STAGES(SYNC_STAGES), .W(ENTRY_W)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_clk_i (line_clk_i),
    .line_data_i(line_data_i),
    .wr_pulse_o (wr_pulse),
    .wr_data_o  (wr_data)
  );

  es_store #(.DEPTH(DEPTH), .W(ENTRY_W), .AW(FW-1)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_pulse),
    .wr_data_i (wr_data),
    .rd_i      (rd_tick),
    .rd_data_o (rd_data_o),
    .rd_valid_o(rd_valid_o),
    .fill_o    (fill_o),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
  );

  es_trim_clock #(.DEPTH(DEPTH), .GUARD(GUARD), .NOM(NOM_TICKS), .FW(FW)) u_trim (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .fill_i(fill_o),
    .tick_o(rd_tick),
    .fast_o(trim_fast_o),
    .slow_o(trim_slow_o)
  );

endmodule

// File: rtl/es_elastic_store_chk.sv
module es_elastic_store_chk #(
  parameter int DEPTH = 32,
  parameter int GUARD = 2,
  parameter int NOM   = 8,
  parameter int FW    = $clog2(DEPTH) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_pulse,
  input logic          rd_tick,
  input logic          rd_valid_o,
  input logic [FW-1:0] fill_o,
  input logic          ovf_o,
  input logic          udf_o,
  input logic          trim_fast_o,
  input logic          trim_slow_o
);

  localparam int HALF = DEPTH / 2;

  // Cycles since the previous period end, saturating.
  logic [7:0] gap_q;
  logic       seen_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (rd_tick) begin
      gap_q  <= 8'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 8'hFF) begin
      gap_q <= gap_q + 8'd1;
    end
  end

  p_fill_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o <= FW'(DEPTH));

  p_nominal_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick && seen_q && !trim_fast_o && !trim_slow_o |-> gap_q == 8'(NOM));

  p_fast_pick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick && fill_o >= FW'(DEPTH - GUARD) |=> trim_fast_o);

  p_fast_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick && seen_q && trim_fast_o |-> gap_q == 8'(NOM - 1));

  p_slow_pick_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick && fill_o <= FW'(GUARD) |=> trim_slow_o);

  p_slow_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick && seen_q && trim_slow_o |-> gap_q == 8'(NOM + 1));

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);

  p_valid_follows_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick |=> rd_valid_o);

  p_ovf_recenter_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse && !rd_tick && fill_o == FW'(DEPTH) |=> ovf_o && fill_o == FW'(HALF));

  p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_udf_recenter_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_tick && fill_o == '0 |=> udf_o && fill_o == FW'(HALF));

  p_udf_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udf_o |=> udf_o);

  p_wr_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse |=> !wr_pulse);

  p_trim_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trim_fast_o && trim_slow_o));

endmodule

bind es_elastic_store es_elastic_store_chk #(
  .DEPTH(DEPTH), .GUARD(GUARD), .NOM(NOM_TICKS), .FW(FW)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_pulse   (wr_pulse),
  .rd_tick    (rd_tick),
  .rd_valid_o (rd_valid_o),
  .fill_o     (fill_o),
  .ovf_o      (ovf_o),
  .udf_o      (udf_o),
  .trim_fast_o(trim_fast_o),
  .trim_slow_o(trim_slow_o)
);

// File: tb/es_elastic_store_bench.sv
`timescale 1ns/1ps
module es_elastic_store_bench;

  localparam int DEPTH = 32;
  localparam int EW    = 2;
  localparam int GUARD = 2;
  localparam int NOM   = 8;
  localparam int FW    = $clog2(DEPTH) + 1;
  localparam int HALF  = DEPTH / 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_clk = 1'b0;
  logic [EW-1:0] line_data = '0;
  logic [EW-1:0] rd_data;
  logic          rd_valid;
  logic [FW-1:0] fill;
  logic          ovf, udf, tfast, tslow;

  always #2.5 clk = ~clk;

  es_elastic_store #(.DEPTH(DEPTH), .ENTRY_W(EW), .GUARD(GUARD), .NOM_TICKS(NOM))
  u_es_elastic_store (
    .clk_i(clk), .rst_ni(rst_n), .line_clk_i(line_clk), .line_data_i(line_data),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid), .fill_o(fill),
    .ovf_o(ovf), .udf_o(udf), .trim_fast_o(tfast), .trim_slow_o(tslow)
  );

  int            n_cmp = 0, n_bad = 0;
  logic [EW-1:0] q[$];
  bit            chk_en = 0;
  bit            done = 0;
  logic [7:0]    lfsr = 8'hA5;

  int gap = 0, exp_len = 0, prev_fill = HALF;
  bit have_exp = 0, prev_valid = 0, prev_ovf = 0, prev_udf = 0;
  int n_nom = 0, n_fast = 0, n_slow = 0, n_ovf_rise = 0, n_udf_rise = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pop, period length and flag behaviour.
  always @(negedge clk) begin
    if (!rst_n) begin
      gap = 0; have_exp = 0; prev_fill = HALF;
      prev_valid = 0; prev_ovf = 0; prev_udf = 0;
    end else begin
      if (rd_valid) begin
        check(!prev_valid, "R6 valid pulse width", 2, 1);
        if (have_exp)
          check(gap == exp_len, (exp_len == NOM-1) ? "R4 short period" :
                                (exp_len == NOM+1) ? "R5 long period" : "R3 nominal period",
                gap, exp_len);
        exp_len = (prev_fill >= DEPTH-GUARD) ? NOM-1 :
                  (prev_fill <= GUARD)       ? NOM+1 : NOM;
        if (exp_len == NOM-1) n_fast++; else if (exp_len == NOM+1) n_slow++; else n_nom++;
        check(tfast == (exp_len == NOM-1), "R10 fast flag", int'(tfast), int'(exp_len == NOM-1));
        check(tslow == (exp_len == NOM+1), "R10 slow flag", int'(tslow), int'(exp_len == NOM+1));
        have_exp = 1;
        gap = 1;
        if (chk_en && q.size() > 0) begin
          logic [EW-1:0] e;
          e = q.pop_front();
          check(rd_data == e, "R2 data order", int'(rd_data), int'(e));
        end
      end else begin
        gap++;
      end
      if (ovf && !prev_ovf) begin
        n_ovf_rise++;
        check(fill == FW'(HALF), "R7 recentre on overflow", int'(fill), HALF);
      end
      if (udf && !prev_udf) begin
        n_udf_rise++;
        check(fill == FW'(HALF), "R8 recentre on underflow", int'(fill), HALF);
      end
      prev_valid = rd_valid;
      prev_ovf   = ovf;
      prev_udf   = udf;
      prev_fill  = int'(fill);
    end
  end

  // Driver: one line bit, strobe high for hi ticks, low for lo ticks.
  task automatic send_one(input logic [EW-1:0] d, input int hi, input int lo, input bit push);
    line_data = d;
    line_clk  = 1'b1;
    if (push) q.push_back(d);
    repeat (hi) @(negedge clk);
    line_clk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input int per, input int hi, input bit push);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      send_one(lfsr[EW-1:0], hi, per - hi, push);
    end
  endtask

  task automatic prefill();
    q.delete();
    for (int i = 0; i < HALF; i++) q.push_back('0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int s_fast, s_slow, waited;
    prefill();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fill == FW'(HALF), "R1 reset fill", int'(fill), HALF);
    check(!ovf && !udf, "R1 reset flags", int'({ovf, udf}), 0);
    check(!tfast && !tslow, "R1 reset trim", int'({tfast, tslow}), 0);
    check(!rd_valid && rd_data == '0, "R1 reset output", int'({rd_valid, rd_data}), 0);
    chk_en = 1;

    // Matched rate: no trims expected.
    send_bits(200, 8, 4, 1);
    check(n_fast == 0 && n_slow == 0, "R3 no trim at matched rate", n_fast + n_slow, 0);
    check(n_nom > 100, "R3 nominal periods seen", n_nom, 101);

    // Line one tick fast: shortened periods.
    s_fast = n_fast;
    send_bits(700, 7, 3, 1);
    check(n_fast > s_fast, "R4 shortened periods used", n_fast - s_fast, 1);
    check(!ovf, "R4 no overflow under fast line", int'(ovf), 0);

    // Line one tick slow: lengthened periods.
    s_slow = n_slow;
    send_bits(700, 9, 4, 1);
    check(n_slow > s_slow, "R5 lengthened periods used", n_slow - s_slow, 1);
    check(!udf, "R5 no underflow under slow line", int'(udf), 0);

    // Line far too fast: overflow.
    chk_en = 0;
    q.delete();
    send_bits(300, 5, 2, 0);
    check(ovf, "R7 overflow flagged", int'(ovf), 1);
    check(n_ovf_rise == 1, "R7 single rise of overflow", n_ovf_rise, 1);
    repeat (60) @(negedge clk);
    check(ovf, "R7 overflow sticky", int'(ovf), 1);

    // Fresh reset, long-high strobes, then starve the store.
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    prefill();
    rst_n = 1'b1;
    @(negedge clk);
    check(!ovf, "R7 flag cleared by reset", int'(ovf), 0);
    check(fill == FW'(HALF), "R1 fill after second reset", int'(fill), HALF);
    chk_en = 1;
    send_one(2'b01, 20, 4, 1);
    send_one(2'b10, 20, 4, 1);
    send_one(2'b11, 20, 4, 1);
    waited = 0;
    while (!udf && waited < 3000) begin
      @(negedge clk);
      waited++;
    end
    check(udf, "R8 underflow flagged", int'(udf), 1);
    check(q.size() == 0, "R9 one entry per strobe edge", q.size(), 0);
    repeat (30) @(negedge clk);
    check(udf, "R8 underflow sticky", int'(udf), 1);
    check(!ovf, "R8 no overflow while starved", int'(ovf), 0);
    finish_run();
  end

endmodule